// File: doc/BRIEF.md
# Serial Attenuator Programming Master

This block sits on the host side of a digital step attenuator that is programmed over a three-wire serial port: a data line, a shift clock and a latch enable. A client hands it a 5-bit attenuation code through a valid/ready handshake. The block builds a 6-bit word: the five code bits, most significant first, then a stop bit that is always zero. It shifts the word out on the data and clock lines and then raises the latch enable for a fixed width to commit the word.

Every edge of the serial waveform is derived from the system clock through cycle-count parameters. These are the clock high time, the data setup time before a rising edge, the data hold time after a falling edge, and the latch pulse width. At elaboration they are compared with the minimum times the port demands at the stated system clock frequency. Ready stays low and busy stays high from the cycle after acceptance until the latch enable falls. A single-cycle done pulse marks that moment. A request that is still held then is taken in the same cycle.

Top module: `atten_ser_master`

## Requirements
- R1: After reset the serial clock, latch enable and data outputs are low, ready is high, busy is low and done is low.
- R2: A request is taken only on a cycle where valid and ready are both high. From the next cycle until the latch enable has fallen, ready is low and busy is high.
- R3: Each transaction produces exactly six rising clock edges. The data sampled on them is code bit 4, 3, 2, 1, 0 in that order, then a stop bit of 0.
- R4: The serial clock idles low, and each high phase lasts exactly HIGH_CYC system cycles. Between rising edges the clock stays low for at least SETUP_CYC+HOLD_CYC cycles.
- R5: Data changes only while the serial clock is low. It is stable for at least SETUP_CYC cycles before each rising edge and for at least HOLD_CYC cycles after each falling edge.
- R6: Latch enable stays low while bits are shifted. It rises exactly HOLD_CYC+SETUP_CYC cycles after the last falling clock edge.
- R7: Latch enable stays high for exactly LE_CYC cycles, with the serial clock low.
- R8: Done is high for exactly one cycle: the first cycle in which the latch enable is low again. Ready is high in that same cycle.
- R9: Valid and code changes made while busy are ignored. The committed word is the one accepted, and no extra frame follows.
- R10: A request held high through the end of a transaction is accepted in the cycle done is high. Its frame follows with no idle gap.
- R11: With the defaults at 100 MHz, the clock high and low times are at least 30 ns, the clock period is at least 100 ns, setup and hold are at least 10 ns, and the latch pulse is at least 30 ns. A parameter set that breaks any of these stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Ready to accept a request |
| req_atten_i | input | 5 | Attenuation code, one dB per LSB |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse when the word is latched |
| ser_data_o | output | 1 | Serial data line |
| ser_clk_o | output | 1 | Serial shift clock |
| ser_le_o | output | 1 | Latch enable |

## Verification
Two events can fall in the same cycle: the done pulse that closes one transaction, and the acceptance of the next request. The bench provokes this by holding valid high with a new code through the whole of a transaction. In the cycle done is high it expects ready high as well. One cycle later it expects busy high again, and it expects the monitor to capture both frames in order, with the first frame unaffected by the code that changed while busy.

// File: rtl/atten_pkg.sv
package atten_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_HIGH,
    PH_HOLD,
    PH_LESET,
    PH_LEHI
  } phase_e;

  // true when cyc system cycles cover ns nanoseconds at mhz
  function automatic bit covers_ns(input int cyc, input int ns, input int mhz);
    return (cyc * 1000) >= (ns * mhz);
  endfunction
endpackage

// File: rtl/atten_phase_timer.sv
module atten_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/atten_frame_shifter.sv
module atten_frame_shifter #(
  parameter int ATTEN_W = 5,
  localparam int FRAME_W = ATTEN_W + 1,
  localparam int IDX_W = $clog2(FRAME_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic [ATTEN_W-1:0] atten_i,
  output logic               bit_o,
  output logic               last_o
);
  logic [FRAME_W-1:0] sr_q;
  logic [IDX_W-1:0]   idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      sr_q  <= {atten_i, 1'b0};  // stop bit forced low
      idx_q <= '0;
    end else if (shift_i) begin
      sr_q  <= {sr_q[FRAME_W-2:0], 1'b0};
      idx_q <= idx_q + 1'b1;
    end
  end

  assign bit_o  = sr_q[FRAME_W-1];
  assign last_o = (idx_q == IDX_W'(FRAME_W - 1));
endmodule

// File: rtl/atten_ser_master.sv
module atten_ser_master
  import atten_pkg::*;
#(
  parameter int SYS_MHZ   = 100,
  parameter int HIGH_CYC  = 5,
  parameter int SETUP_CYC = 3,
  parameter int HOLD_CYC  = 2,
  parameter int LE_CYC    = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  output logic       req_ready_o,
  input  logic [4:0] req_atten_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       ser_data_o,
  output logic       ser_clk_o,
  output logic       ser_le_o
);
  localparam int ATTEN_W = 5;
  localparam int MAX_A   = (HIGH_CYC > SETUP_CYC) ? HIGH_CYC : SETUP_CYC;
  localparam int MAX_B   = (HOLD_CYC > LE_CYC) ? HOLD_CYC : LE_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  // R11 elaboration-time timing checks
  if (!covers_ns(HIGH_CYC, 30, SYS_MHZ)) begin : g_bad_high
    $error("serial clock high time below 30 ns");
  end
  if (!covers_ns(SETUP_CYC + HOLD_CYC, 30, SYS_MHZ)) begin : g_bad_low
    $error("serial clock low time below 30 ns");
  end
  if (!covers_ns(HIGH_CYC + SETUP_CYC + HOLD_CYC, 100, SYS_MHZ)) begin : g_bad_per
    $error("serial clock above 10 MHz");
  end
  if (!covers_ns(SETUP_CYC, 10, SYS_MHZ) || SETUP_CYC < 1) begin : g_bad_setup
    $error("data or latch setup below 10 ns");
  end
  if (!covers_ns(HOLD_CYC, 10, SYS_MHZ) || HOLD_CYC < 1) begin : g_bad_hold
    $error("data hold below 10 ns");
  end
  if (!covers_ns(LE_CYC, 30, SYS_MHZ)) begin : g_bad_le
    $error("latch pulse below 30 ns");
  end

  phase_e           ph_q, ph_d;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             fr_load, fr_shift, fr_last;
  logic             done_q;
  logic             accept;

  assign accept = req_valid_i && (ph_q == PH_IDLE);

  atten_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  atten_frame_shifter #(.ATTEN_W(ATTEN_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (fr_load),
    .shift_i (fr_shift),
    .atten_i (req_atten_i),
    .bit_o   (ser_data_o),
    .last_o  (fr_last)
  );

  always_comb begin
    ph_d     = ph_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    fr_load  = 1'b0;
    fr_shift = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (accept) begin
        ph_d = PH_SETUP; tmr_load = 1'b1; tmr_val = CNT_W'(SETUP_CYC - 1); fr_load = 1'b1;
      end
      PH_SETUP: if (tmr_zero) begin
        ph_d = PH_HIGH; tmr_load = 1'b1; tmr_val = CNT_W'(HIGH_CYC - 1);
      end
      PH_HIGH: if (tmr_zero) begin
        ph_d = PH_HOLD; tmr_load = 1'b1; tmr_val = CNT_W'(HOLD_CYC - 1);
      end
      PH_HOLD: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(SETUP_CYC - 1);
        if (fr_last) ph_d = PH_LESET;
        else begin
          ph_d = PH_SETUP; fr_shift = 1'b1;
        end
      end
      PH_LESET: if (tmr_zero) begin
        ph_d = PH_LEHI; tmr_load = 1'b1; tmr_val = CNT_W'(LE_CYC - 1);
      end
      PH_LEHI: if (tmr_zero) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      done_q <= (ph_q == PH_LEHI) && tmr_zero;
    end
  end

  assign req_ready_o = (ph_q == PH_IDLE);
  assign busy_o      = (ph_q != PH_IDLE);
  assign ser_clk_o   = (ph_q == PH_HIGH);
  assign ser_le_o    = (ph_q == PH_LEHI);
  assign done_o      = done_q;

  // R2
  accept_drops_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (!req_ready_o && busy_o));
  // R8
  done_at_le_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($fell(ser_le_o) && req_ready_o));
  // R3
  stop_bit_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ser_le_o) |-> !ser_data_o);
  // R5
  data_moves_clk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ser_data_o) |-> (!ser_clk_o && !$past(ser_clk_o)));
  // R6
  le_clk_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_le_o |-> !ser_clk_o);
  // R7
  le_fall_ends_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ser_le_o) |-> !busy_o);
endmodule

// File: tb/atten_ser_master_test.sv
module atten_ser_master_test;
  localparam int HIGH_CYC = 5, SETUP_CYC = 3, HOLD_CYC = 2, LE_CYC = 3;
  localparam int PERIOD_NS = 10;

  logic clk = 0, rst_n = 0;
  logic valid = 0;
  logic [4:0] atten = '0;
  logic ready, busy, done, sdata, sclk, sle;

  int n_chk = 0, n_fail = 0;

  atten_ser_master uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_atten_i(atten), .busy_o(busy), .done_o(done),
    .ser_data_o(sdata), .ser_clk_o(sclk), .ser_le_o(sle)
  );

  always #(PERIOD_NS/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // wire-level monitor, samples on falling system clock edge
  logic p_clk = 0, p_data = 0, p_le = 0;
  int data_age = 1000, fall_age = 1000, hi_cnt = 0, lo_cnt = 1000, le_hi = 0, nbits = 0;
  logic [5:0] bits = '0;
  logic [4:0] frames [0:15];
  int nframes = 0;
  int min_setup = 1000, min_hold = 1000;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sdata !== p_data) begin
        chk(!sclk, "R5 data change with clock high", sclk, 0);
        if (fall_age < min_hold) min_hold = fall_age;
        chk(fall_age >= HOLD_CYC, "R5 hold after fall", fall_age, HOLD_CYC);
        data_age = 0;
      end
      if (sclk && !p_clk) begin
        chk(data_age >= SETUP_CYC, "R5 setup before rise", data_age, SETUP_CYC);
        if (data_age < min_setup) min_setup = data_age;
        if (nbits > 0) chk(lo_cnt >= SETUP_CYC + HOLD_CYC, "R4 low time", lo_cnt, SETUP_CYC + HOLD_CYC);
        chk(!sle, "R6 le low while shifting", sle, 0);
        bits = {bits[4:0], sdata};
        nbits++;
        hi_cnt = 0;
      end
      if (!sclk && p_clk) begin
        chk(hi_cnt == HIGH_CYC, "R4 high time", hi_cnt, HIGH_CYC);
        fall_age = 0;
        lo_cnt = 0;
      end
      if (sle && !p_le) begin
        chk(fall_age == HOLD_CYC + SETUP_CYC, "R6 le rise delay", fall_age, HOLD_CYC + SETUP_CYC);
        chk(nbits == 6, "R3 bit count", nbits, 6);
        chk(bits[0] == 1'b0, "R3 stop bit", bits[0], 0);
        if (nframes < 16) frames[nframes] = bits[5:1];
        nframes++;
        le_hi = 0;
      end
      if (sle) chk(!sclk, "R7 clock low during le", sclk, 0);
      if (!sle && p_le) begin
        chk(le_hi == LE_CYC, "R7 le width", le_hi, LE_CYC);
        chk(done == 1'b1, "R8 done at le fall", done, 1);
        chk(ready == 1'b1, "R8 ready at le fall", ready, 1);
        nbits = 0;
      end else if (done) begin
        chk(0, "R8 done outside le fall", done, 0);
      end
      if (busy) chk(!ready, "R2 ready low while busy", ready, 0);
      if (sclk) hi_cnt++; else lo_cnt++;
      if (sle) le_hi++;
      data_age++;
      fall_age++;
    end
    p_clk = sclk; p_data = sdata; p_le = sle;
  end

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  task automatic t_reset();
    chk(sclk == 0 && sle == 0 && sdata == 0, "R1 serial lines low", {sclk, sle, sdata}, 0);
    chk(ready == 1 && busy == 0 && done == 0, "R1 handshake idle", {ready, busy, done}, 3'b100);
  endtask

  task automatic t_single(input logic [4:0] v);
    int f0 = nframes;
    @(negedge clk);
    valid = 1; atten = v;
    @(negedge clk);
    chk(!ready && busy, "R2 taken", {ready, busy}, 2'b01);
    valid = 0; atten = ~v;
    wait_idle();
    repeat (3) @(negedge clk);
    chk(nframes == f0 + 1, "R3 one frame", nframes - f0, 1);
    chk(frames[f0] == v, "R3 frame bits", frames[f0], v);
  endtask

  task automatic t_no_valid();
    int f0 = nframes;
    repeat (20) @(negedge clk);
    chk(nframes == f0 && !sclk && !busy, "R2 no request no frame", nframes - f0, 0);
  endtask

  task automatic t_ignore_busy();
    int f0 = nframes;
    @(negedge clk);
    valid = 1; atten = 5'd9;
    @(negedge clk);
    atten = 5'd22;
    repeat (20) @(negedge clk);
    valid = 0;
    wait_idle();
    repeat (20) @(negedge clk);
    chk(nframes == f0 + 1, "R9 no extra frame", nframes - f0, 1);
    chk(frames[f0] == 5'd9, "R9 code kept", frames[f0], 9);
  endtask

  task automatic t_back_to_back();
    int f0 = nframes;
    @(negedge clk);
    valid = 1; atten = 5'd19;
    @(negedge clk);
    atten = 5'd12;
    while (!done) @(negedge clk);
    chk(ready, "R10 ready with done", ready, 1);
    @(negedge clk);
    chk(busy && !ready, "R10 taken on done cycle", busy, 1);
    valid = 0;
    wait_idle();
    repeat (3) @(negedge clk);
    chk(nframes == f0 + 2, "R10 two frames", nframes - f0, 2);
    chk(frames[f0] == 5'd19, "R10 first frame", frames[f0], 19);
    chk(frames[f0 + 1] == 5'd12, "R10 second frame", frames[f0 + 1], 12);
  endtask

  task automatic t_timing_ns();
    chk(HIGH_CYC * PERIOD_NS >= 30, "R11 high ns", HIGH_CYC * PERIOD_NS, 30);
    chk((SETUP_CYC + HOLD_CYC) * PERIOD_NS >= 30, "R11 low ns", (SETUP_CYC + HOLD_CYC) * PERIOD_NS, 30);
    chk((HIGH_CYC + SETUP_CYC + HOLD_CYC) * PERIOD_NS >= 100, "R11 period ns",
        (HIGH_CYC + SETUP_CYC + HOLD_CYC) * PERIOD_NS, 100);
    chk(min_setup * PERIOD_NS >= 10, "R11 setup ns", min_setup * PERIOD_NS, 10);
    chk(min_hold * PERIOD_NS >= 10, "R11 hold ns", min_hold * PERIOD_NS, 10);
    chk(LE_CYC * PERIOD_NS >= 30, "R11 le ns", LE_CYC * PERIOD_NS, 30);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_no_valid();
    t_single(5'd0);
    t_single(5'd31);
    t_single(5'd21);
    t_single(5'd10);
    t_single(5'd1);
    t_single(5'd16);
    t_ignore_busy();
    t_back_to_back();
    t_timing_ns();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule